// File: doc/BRIEF.md
# Vectored Interrupt Device Interface

This block is the interrupt side of one I/O device interface. The device has two ready conditions: one for input and one for output. Each has an enable bit and a latched request bit. A small register port lets software set the enables, read the flags and requests, and clear requests. While an enabled request is latched and not yet answered, the block raises its contribution to a request line that all devices share.

The acknowledge runs from device to device as a serial chain. When the block receives the acknowledge and has its request raised, it keeps the acknowledge from going further down the chain. In the same cycle it presents its vector code. If it has no raised request, the acknowledge passes straight through, combinationally, to the next device. The vector leaves on a valid/ready pair. `vec_valid` is the valid, and the incoming acknowledge is the ready. A vector is offered only in a cycle where the acknowledge is high, and it is taken in that same cycle. Nothing waits: if the acknowledge drops, the offer drops with it. When the block has answered an acknowledge, it withdraws its request until software has cleared every enabled request bit. Each service therefore causes only one interruption.

Top module: `ivi_device`

## Requirements
- R1: After reset, both enable bits and both request bits read 0, `irq` is 0, and `vec_data` is 0.
- R2: At a clock edge where a source's ready flag is 1 and its enable bit is 1, that source's request bit becomes 1. The only exception is when the same edge clears the bit, because clearing wins.
- R3: While a source's enable bit is 0, its ready flag never sets its request bit.
- R4: A request bit is cleared at the next edge under either of two conditions. One is a write to the status address (`reg_addr`=1) with a 1 in that bit's position: bit 2 clears the input request and bit 3 clears the output request. The other is a pulse on that source's serviced input.
- R5: `irq` is 1 exactly when at least one request bit whose enable is 1 is set and the block has not answered an acknowledge since those requests were raised.
- R6: While `irq` is 0, `ack_out` equals `ack_in` in the same cycle.
- R7: While `irq` is 1 and `ack_in` is 1, `ack_out` is 0, `vec_valid` is 1 and `vec_data` equals the vector code parameter. In every other cycle, `vec_valid` is 0 and `vec_data` is 0.
- R8: After an edge with `ack_in` and `irq` both 1, `irq` stays 0 until a cycle in which no enabled request bit is set. From then on, R5 applies again.
- R9: A read at the control address (`reg_addr`=0) returns the input enable in bit 0 and the output enable in bit 1. A read at the status address returns the input flag in bit 0, the output flag in bit 1, the input request in bit 2 and the output request in bit 3. All other bits read 0. A write at the control address loads both enables from bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_rdy | input | 1 | Input-ready status flag |
| out_rdy | input | 1 | Output-ready status flag |
| in_served | input | 1 | Pulse: input transfer serviced, clears input request |
| out_served | input | 1 | Pulse: output transfer serviced, clears output request |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| irq | output | 1 | Contribution to the shared request line |
| ack_in | input | 1 | Acknowledge from the previous stage; also the vector ready |
| ack_out | output | 1 | Acknowledge passed to the next stage |
| vec_valid | output | 1 | Vector offered on vec_data |
| vec_data | output | VEC_W | Vector code, zero when not offered |

## Verification
Three kinds of internal fault show up at the ports. A corrupted request or enable bit appears on the next status or control read. It also changes `irq` in the very cycle after the faulty edge. A wrong answered-state appears two ways: `irq` stays high after an acknowledge, or `irq` never comes back once the requests are cleared. Either shows one cycle after the acknowledge or clear edge. A fault in the chain logic appears combinationally within the same acknowledge cycle: the acknowledge leaks past a requesting device, a vector appears while `ack_out` is still high, or `vec_data` carries a nonzero value when no vector is offered.

// File: rtl/ivi_pkg.sv
package ivi_pkg;
  localparam int NSRC     = 2;
  localparam int FLAG_LSB = 0;
  localparam int REQ_LSB  = FLAG_LSB + NSRC;

  typedef enum logic [0:0] {
    ADDR_CTRL = 1'b0,
    ADDR_STAT = 1'b1
  } ivi_addr_e;
endpackage

// File: rtl/ivi_src.sv
module ivi_src (
  input  logic clk,
  input  logic rst_n,
  input  logic flag,
  input  logic en,
  input  logic clr,
  output logic req
);
  always_ff @(posedge clk) begin
    if (!rst_n)          req <= 1'b0;
    else if (clr)        req <= 1'b0;
    else if (flag && en) req <= 1'b1;
  end

  AST_SET_ON_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && en && !clr) |=> req); // R2
  AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !req) |=> !req); // R3
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !req); // R4
endmodule

// File: rtl/ivi_ctrl.sv
module ivi_ctrl
  import ivi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NSRC-1:0]   flags,
  input  logic [NSRC-1:0]   reqs,
  input  logic [NSRC-1:0]   served,
  output logic [NSRC-1:0]   en,
  output logic [NSRC-1:0]   clr,
  output logic [DATA_W-1:0] rdata
);
  logic wr_ctrl, wr_stat;
  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n)       en <= '0;
    else if (wr_ctrl) en <= reg_wdata[NSRC-1:0];
  end

  always_comb begin
    clr = served;
    if (wr_stat) clr = clr | reg_wdata[REQ_LSB +: NSRC];
  end

  always_comb begin
    rdata = '0;
    if (reg_addr == ADDR_CTRL) begin
      rdata[NSRC-1:0] = en;
    end else begin
      rdata[FLAG_LSB +: NSRC] = flags;
      rdata[REQ_LSB +: NSRC]  = reqs;
    end
  end

  AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (en == $past(reg_wdata[NSRC-1:0]))); // R9
endmodule

// File: rtl/ivi_ack_chain.sv
module ivi_ack_chain #(
  parameter int               VEC_W    = 8,
  parameter logic [VEC_W-1:0] VEC_CODE = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend,
  input  logic             ack_in,
  output logic             irq,
  output logic             ack_out,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_data
);
  logic answered;

  assign irq       = pend && !answered;
  assign vec_valid = ack_in && irq;
  assign ack_out   = ack_in && !irq;
  assign vec_data  = vec_valid ? VEC_CODE : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)         answered <= 1'b0;
    else if (vec_valid) answered <= 1'b1;
    else if (!pend)     answered <= 1'b0;
  end

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (ack_out == ack_in)); // R6
  AST_BLOCK_AND_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ack_in) |-> (!ack_out && vec_valid && vec_data == VEC_CODE)); // R7
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> (vec_data == '0)); // R7
  AST_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && irq) |=> !irq); // R8
endmodule

// File: rtl/ivi_device.sv
module ivi_device
  import ivi_pkg::*;
#(
  parameter int               DATA_W   = 8,
  parameter int               VEC_W    = 8,
  parameter logic [VEC_W-1:0] VEC_CODE = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_rdy,
  input  logic              out_rdy,
  input  logic              in_served,
  input  logic              out_served,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  input  logic              ack_in,
  output logic              ack_out,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_data
);
  logic [NSRC-1:0] flags, served, en, clr, reqs;
  logic            pend;

  assign flags  = {out_rdy, in_rdy};
  assign served = {out_served, in_served};
  assign pend   = |(reqs & en);

  ivi_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .flags(flags), .reqs(reqs), .served(served),
    .en(en), .clr(clr), .rdata(reg_rdata)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    ivi_src u_src (
      .clk(clk), .rst_n(rst_n), .flag(flags[g]), .en(en[g]),
      .clr(clr[g]), .req(reqs[g])
    );
  end

  ivi_ack_chain #(.VEC_W(VEC_W), .VEC_CODE(VEC_CODE)) u_chain (
    .clk(clk), .rst_n(rst_n), .pend(pend), .ack_in(ack_in), .irq(irq),
    .ack_out(ack_out), .vec_valid(vec_valid), .vec_data(vec_data)
  );

  AST_IRQ_NEEDS_ENABLED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(reqs & en))); // R5
endmodule

// File: tb/ivi_device_tb.sv
module ivi_device_tb;
  localparam int CLK_P = 10;
  localparam int DW = 8;
  localparam int VW = 8;
  localparam logic [VW-1:0] CODE = 8'h5C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_rdy = 0, out_rdy = 0, in_served = 0, out_served = 0;
  logic reg_addr = 0, reg_wr = 0, ack_in = 0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq, ack_out, vec_valid;
  logic [VW-1:0] vec_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [1:0] m_en = '0, m_req = '0;
  logic       m_ans = 0;

  always #(CLK_P/2) clk = ~clk;

  ivi_device #(.DATA_W(DW), .VEC_W(VW), .VEC_CODE(CODE)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_rdy(in_rdy), .out_rdy(out_rdy),
    .in_served(in_served), .out_served(out_served), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .ack_in(ack_in), .ack_out(ack_out), .vec_valid(vec_valid),
    .vec_data(vec_data)
  );

  function automatic logic exp_irq();
    return (|(m_req & m_en)) && !m_ans;
  endfunction

  function automatic logic [DW-1:0] exp_rdata(logic a);
    logic [DW-1:0] r = '0;
    if (!a) r[1:0] = m_en;
    else begin r[1:0] = {out_rdy, in_rdy}; r[3:2] = m_req; end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    logic ei = exp_irq();
    logic ev = ack_in && ei;
    chk("R5 R8 irq", 32'(irq), 32'(ei));
    chk("R6 ack_out", 32'(ack_out), 32'(ack_in && !ei));
    chk("R7 vec_valid", 32'(vec_valid), 32'(ev));
    chk("R7 vec_data", 32'(vec_data), ev ? 32'(CODE) : 32'd0);
    chk(reg_addr ? "R2 R3 R4 R9 status" : "R9 control", 32'(reg_rdata), 32'(exp_rdata(reg_addr)));
  endtask

  task automatic model_step();
    logic [1:0] clr = {out_served, in_served};
    logic [1:0] set = {out_rdy, in_rdy} & m_en;
    logic pend = |(m_req & m_en);
    logic ei = exp_irq();
    if (reg_wr && reg_addr) clr = clr | reg_wdata[3:2];
    if (ack_in && ei) m_ans = 1'b1;
    else if (!pend) m_ans = 1'b0;
    m_req = (m_req | set) & ~clr;
    if (reg_wr && !reg_addr) m_en = reg_wdata[1:0];
  endtask

  task automatic cycle();
    #1;
    check_outputs();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    reg_addr = 0; #1; chk("R1 control", 32'(reg_rdata), 32'd0);
    reg_addr = 1; #1; chk("R1 status", 32'(reg_rdata), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 vec_data", 32'(vec_data), 32'd0);

    // R3 directed: flags high while disabled
    in_rdy = 1; out_rdy = 1; reg_addr = 1;
    repeat (3) cycle();
    // R9/R2 directed: enable input only, acknowledge, withdraw (R8)
    reg_addr = 0; reg_wr = 1; reg_wdata = 8'h01; cycle();
    reg_wr = 0; reg_addr = 1; cycle();
    ack_in = 1; cycle();
    cycle();          // R8: irq withdrawn, ack now passes
    ack_in = 0; in_rdy = 0;
    reg_wr = 1; reg_wdata = 8'h04; cycle();   // R4 W1C
    reg_wr = 0; cycle(); cycle();
    // R4 clear wins over set
    in_rdy = 1; in_served = 1; cycle();
    in_served = 0; cycle();

    for (int i = 0; i < 3000; i++) begin
      in_rdy     = ($urandom % 3) == 0;
      out_rdy    = ($urandom % 3) == 0;
      in_served  = ($urandom % 12) == 0;
      out_served = ($urandom % 12) == 0;
      reg_addr   = $urandom % 2;
      reg_wr     = ($urandom % 6) == 0;
      reg_wdata  = DW'($urandom);
      ack_in     = ($urandom % 3) == 0;
      cycle();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule